// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block is the device side of a three-wire serial EEPROM with 1 kbit of storage, arranged as 64 words of 16 bits and held in on-chip registers. A host drives a select line, a serial clock and a serial data input. The block drives one serial data output. All three inputs are asynchronous to the block's system clock. They pass through synchronisers, and the block then detects their edges itself. The serial clock must therefore run several times slower than the system clock.

Each transfer starts when select goes high. The block skips low bits until the first high bit, which is the start bit. It then takes a 2-bit opcode and a 6-bit address. A read streams the addressed word back. Write and write-all take 16 more data bits. Erase and erase-all fill words with ones. Two further commands set or clear a write-enable latch. The latch comes up cleared and must be set before any command can change the array. Lowering select at any point ends the transfer, and a command that is not yet complete leaves the array unchanged.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset every word reads 0x0000, the write-enable latch is clear and `sdo_o` is low.
- R2: A transfer begins on a rising edge of `sel_i`. Data bits are sampled on rising edges of `sck_i`. Low bits received before the first high bit are skipped. The header is a start bit of 1, then the opcode (2 bits), then the address (6 bits), each sent MSB first.
- R3: Opcode 2'b10 (read) returns the addressed word MSB first. Each bit changes on a falling edge of `sck_i`. The first bit appears on the falling edge that follows the rising edge of the last address bit.
- R4: Opcode 2'b01 (write) takes 16 data bits, MSB first, after the header. If the latch is set, the word is stored at the address once the 16th bit is sampled.
- R5: Opcode 2'b11 (erase) sets the addressed word to 0xFFFF if the latch is set.
- R6: With opcode 2'b00, address bits [5:4] = 2'b11 set the latch and 2'b00 clear it. The latch keeps its value until the next such command or a reset.
- R7: With opcode 2'b00, address bits [5:4] = 2'b01 (write-all) take 16 data bits. If the latch is set, that value is stored in all 64 words.
- R8: With opcode 2'b00, address bits [5:4] = 2'b10 (erase-all) set all 64 words to 0xFFFF if the latch is set.
- R9: While the latch is clear, write, erase, write-all and erase-all leave every word unchanged.
- R10: If `sel_i` falls before a write's 16th data bit is sampled, the array is not changed.
- R11: `sdo_o` is low whenever no read data bit is being presented: during the header, after the 16th read bit, and while `sel_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Device select, active high, asynchronous |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |

## Verification
The bench stresses the write-enable latch in both directions. Every modifying command is sent once while the latch is clear and once while it is set, and the words are then read back. A design that ignored the latch would show altered words, and one that never latched the enable would keep stale words. Extra zeros are sent before a start bit, to catch a decoder that counts from select instead of from the start bit. A write is cut short by dropping select, to catch a design that commits partial data. The bench also checks that the output is low during the header and on the clock after the last read bit, which exposes a read shifter that starts one edge early or runs one edge too long. A reset in the middle of the run must clear both the array and the latch.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
   typedef enum logic [2:0] {
      MW_NOP, MW_WRITE, MW_WRALL, MW_ERASE, MW_ERALL, MW_WEN, MW_WDS
   } mw_cmd_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EXT_WDS   = 2'b00;
   localparam logic [1:0] EXT_WRALL = 2'b01;
   localparam logic [1:0] EXT_ERALL = 2'b10;
   localparam logic [1:0] EXT_WEN   = 2'b11;
endpackage

// File: rtl/mwe_sync.sv
module mwe_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] lvl_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mwe_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("mwe_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/mwe_store.sv
module mwe_store
   import mwe_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid_i,
   input  mw_cmd_e           cmd_kind_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [WORD_W-1:0] cmd_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [WORD_W-1:0] rd_word_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0][WORD_W-1:0] mem_q;
   logic                         wen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wen_q <= 1'b0;
      end else if (cmd_valid_i) begin
         if (cmd_kind_i == MW_WEN)      wen_q <= 1'b1;
         else if (cmd_kind_i == MW_WDS) wen_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_q <= '0;
      end else if (cmd_valid_i && wen_q) begin
         for (int i = 0; i < DEPTH; i++) begin
            unique case (cmd_kind_i)
               MW_WRITE: if (cmd_addr_i == ADDR_W'(i)) mem_q[i] <= cmd_data_i;
               MW_ERASE: if (cmd_addr_i == ADDR_W'(i)) mem_q[i] <= '1;
               MW_WRALL: mem_q[i] <= cmd_data_i;
               MW_ERALL: mem_q[i] <= '1;
               default:  ;
            endcase
         end
      end
   end

   assign rd_word_o = mem_q[rd_addr_i];

   assert_locked_array_R9: assert property (@(posedge clk) disable iff (rst)
      !wen_q |=> $stable(mem_q));
   assert_latch_set_R6: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid_i && cmd_kind_i == MW_WEN) |=> wen_q);
   assert_latch_clear_R6: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid_i && cmd_kind_i == MW_WDS) |=> !wen_q);
   assert_erase_ones_R5: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid_i && cmd_kind_i == MW_ERASE && wen_q)
      |=> (mem_q[$past(cmd_addr_i)] == {WORD_W{1'b1}}));
endmodule

// File: rtl/mwe_decoder.sv
module mwe_decoder
   import mwe_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_i,
   input  logic              sck_i,
   input  logic              di_i,
   input  logic [WORD_W-1:0] rd_word_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              cmd_valid_o,
   output mw_cmd_e           cmd_kind_o,
   output logic [WORD_W-1:0] cmd_data_o,
   output logic              so_o
);
   localparam int HDR_BITS = ADDR_W + 2;
   localparam int CNT_MAX  = (WORD_W > HDR_BITS) ? WORD_W : HDR_BITS;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mwe_decoder: ADDR_W must be at least 2");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("mwe_decoder: WORD_W must be at least 2");
      end
   endgenerate

   typedef enum logic [2:0] {S_IDLE, S_HUNT, S_HDR, S_WDATA, S_RDATA, S_DONE} dstate_e;

   dstate_e             state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [HDR_BITS-2:0] hdr_q;
   logic [WORD_W-2:0]   dat_q;
   logic [WORD_W-2:0]   rsh_q;
   logic                all_q;
   logic                cs_prev_q, sck_prev_q;

   logic                cs_rise, sck_rise, sck_fall;
   logic [HDR_BITS-1:0] hdr_nx;
   logic [1:0]          op_nx, ext_nx;
   logic [WORD_W-1:0]   dat_nx;

   always_comb begin
      cs_rise  = cs_i & ~cs_prev_q;
      sck_rise = sck_i & ~sck_prev_q;
      sck_fall = ~sck_i & sck_prev_q;
      hdr_nx   = {hdr_q, di_i};
      op_nx    = hdr_nx[HDR_BITS-1 -: 2];
      ext_nx   = hdr_nx[ADDR_W-1 -: 2];
      dat_nx   = {dat_q, di_i};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_prev_q  <= 1'b0;
         sck_prev_q <= 1'b0;
      end else begin
         cs_prev_q  <= cs_i;
         sck_prev_q <= sck_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= S_IDLE;
         cnt_q       <= '0;
         hdr_q       <= '0;
         dat_q       <= '0;
         rsh_q       <= '0;
         all_q       <= 1'b0;
         addr_o      <= '0;
         cmd_valid_o <= 1'b0;
         cmd_kind_o  <= MW_NOP;
         cmd_data_o  <= '0;
         so_o        <= 1'b0;
      end else begin
         cmd_valid_o <= 1'b0;
         if (!cs_i) begin
            state_q <= S_IDLE;
            so_o    <= 1'b0;
         end else begin
            unique case (state_q)
               S_IDLE: if (cs_rise) state_q <= S_HUNT;
               S_HUNT: if (sck_rise && di_i) begin
                  state_q <= S_HDR;
                  cnt_q   <= '0;
               end
               S_HDR: if (sck_rise) begin
                  hdr_q <= hdr_nx[HDR_BITS-2:0];
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
                     addr_o <= hdr_nx[ADDR_W-1:0];
                     cnt_q  <= '0;
                     unique case (op_nx)
                        OP_READ:  state_q <= S_RDATA;
                        OP_WRITE: begin state_q <= S_WDATA; all_q <= 1'b0; end
                        OP_ERASE: begin
                           state_q <= S_DONE; cmd_valid_o <= 1'b1; cmd_kind_o <= MW_ERASE;
                        end
                        default: begin
                           unique case (ext_nx)
                              EXT_WRALL: begin state_q <= S_WDATA; all_q <= 1'b1; end
                              EXT_ERALL: begin
                                 state_q <= S_DONE; cmd_valid_o <= 1'b1; cmd_kind_o <= MW_ERALL;
                              end
                              EXT_WEN: begin
                                 state_q <= S_DONE; cmd_valid_o <= 1'b1; cmd_kind_o <= MW_WEN;
                              end
                              default: begin
                                 state_q <= S_DONE; cmd_valid_o <= 1'b1; cmd_kind_o <= MW_WDS;
                              end
                           endcase
                        end
                     endcase
                  end
               end
               S_WDATA: if (sck_rise) begin
                  dat_q <= dat_nx[WORD_W-2:0];
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(WORD_W - 1)) begin
                     state_q     <= S_DONE;
                     cmd_valid_o <= 1'b1;
                     cmd_kind_o  <= all_q ? MW_WRALL : MW_WRITE;
                     cmd_data_o  <= dat_nx;
                  end
               end
               S_RDATA: if (sck_fall) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(WORD_W)) begin
                     state_q <= S_DONE;
                     so_o    <= 1'b0;
                  end else if (cnt_q == '0) begin
                     so_o  <= rd_word_i[WORD_W-1];
                     rsh_q <= rd_word_i[WORD_W-2:0];
                  end else begin
                     so_o  <= rsh_q[WORD_W-2];
                     rsh_q <= rsh_q << 1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_sdo_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      (state_q != S_RDATA) |-> !so_o);
   assert_sdo_deselect_R11: assert property (@(posedge clk) disable iff (rst)
      !cs_i |=> !so_o);
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_RDATA) |-> (cnt_q <= CNT_W'(WORD_W)));
   assert_one_cmd_R10: assert property (@(posedge clk) disable iff (rst)
      cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
   import mwe_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sel_i,
   input  logic sck_i,
   input  logic sdi_i,
   output logic sdo_o
);
   logic [2:0]        pins_s;
   logic [ADDR_W-1:0] addr;
   logic              cmd_valid;
   mw_cmd_e           cmd_kind;
   logic [WORD_W-1:0] cmd_data, rd_word;

   mwe_sync #(.STAGES(SYNC_STAGES), .W(3)) i_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i ({sdi_i, sck_i, sel_i}),
      .lvl_o   (pins_s)
   );

   mwe_decoder #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_dec (
      .clk         (clk),
      .rst         (rst),
      .cs_i        (pins_s[0]),
      .sck_i       (pins_s[1]),
      .di_i        (pins_s[2]),
      .rd_word_i   (rd_word),
      .addr_o      (addr),
      .cmd_valid_o (cmd_valid),
      .cmd_kind_o  (cmd_kind),
      .cmd_data_o  (cmd_data),
      .so_o        (sdo_o)
   );

   mwe_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_store (
      .clk         (clk),
      .rst         (rst),
      .cmd_valid_i (cmd_valid),
      .cmd_kind_i  (cmd_kind),
      .cmd_addr_i  (addr),
      .cmd_data_i  (cmd_data),
      .rd_addr_i   (addr),
      .rd_word_o   (rd_word)
   );
endmodule

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
   logic sdo;
   int   nchk = 0, nfail = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   mw_eeprom_slave i_mw_eeprom_slave (
      .clk(clk), .rst(rst), .sel_i(sel), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo)
   );

   localparam int K_RD = 0, K_WR = 1, K_ER = 2, K_ERAL = 3, K_WRAL = 4, K_EN = 5, K_DS = 6;
   localparam int NV = 27;
   // {kind, addr, data, expected read}
   localparam logic [41:0] VEC [NV] = '{
      {4'd0, 6'h0F, 16'h0000, 16'h0000},  // R1 reset contents
      {4'd1, 6'h0F, 16'h5AA5, 16'h0000},  // R9 write while locked
      {4'd0, 6'h0F, 16'h0000, 16'h0000},  // R9
      {4'd5, 6'h00, 16'h0000, 16'h0000},  // R6 enable
      {4'd1, 6'h0F, 16'h5AA5, 16'h0000},  // R4
      {4'd0, 6'h0F, 16'h0000, 16'h5AA5},  // R4 R3
      {4'd1, 6'h00, 16'h1234, 16'h0000},  // R4 lowest address
      {4'd1, 6'h3F, 16'hBEEF, 16'h0000},  // R4 highest address
      {4'd0, 6'h00, 16'h0000, 16'h1234},  // R3
      {4'd0, 6'h3F, 16'h0000, 16'hBEEF},  // R3
      {4'd2, 6'h0F, 16'h0000, 16'h0000},  // R5 erase
      {4'd0, 6'h0F, 16'h0000, 16'hFFFF},  // R5
      {4'd0, 6'h00, 16'h0000, 16'h1234},  // R5 neighbour untouched
      {4'd6, 6'h00, 16'h0000, 16'h0000},  // R6 disable
      {4'd2, 6'h00, 16'h0000, 16'h0000},  // R9 erase while locked
      {4'd0, 6'h00, 16'h0000, 16'h1234},  // R9
      {4'd3, 6'h00, 16'h0000, 16'h0000},  // R9 erase-all while locked
      {4'd0, 6'h3F, 16'h0000, 16'hBEEF},  // R9
      {4'd5, 6'h00, 16'h0000, 16'h0000},  // R6
      {4'd4, 6'h00, 16'hC3A5, 16'h0000},  // R7 write-all
      {4'd0, 6'h15, 16'h0000, 16'hC3A5},  // R7
      {4'd0, 6'h3F, 16'h0000, 16'hC3A5},  // R7
      {4'd3, 6'h00, 16'h0000, 16'h0000},  // R8 erase-all
      {4'd0, 6'h2A, 16'h0000, 16'hFFFF},  // R8
      {4'd6, 6'h00, 16'h0000, 16'h0000},  // R6
      {4'd4, 6'h00, 16'h0000, 16'h0000},  // R9 write-all while locked
      {4'd0, 6'h01, 16'h0000, 16'hFFFF}   // R9
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_start();
      sel = 1'b1; wait_n(4);
   endtask

   task automatic frame_end();
      sck = 1'b0; wait_n(4); sel = 1'b0; wait_n(8);
   endtask

   // n serial clocks, bits[n-1] first; sdo captured at end of each high phase
   task automatic xfer(input logic [31:0] bits, input int n, output logic [31:0] got);
      got = '0;
      for (int i = n - 1; i >= 0; i--) begin
         sck = 1'b0; sdi = bits[i]; wait_n(6);
         sck = 1'b1; wait_n(6);
         got = {got[30:0], sdo};
      end
   endtask

   function automatic logic [31:0] hdr(input logic [1:0] op, input logic [5:0] a);
      return {23'd0, 1'b1, op, a};
   endfunction

   task automatic do_read(input logic [5:0] a, input logic [15:0] exp, input string tag);
      logic [31:0] got;
      frame_start();
      xfer({hdr(2'b10, a), 17'd0}, 26, got);
      frame_end();
      chk({tag, " read data"}, {16'd0, got[16:1]}, {16'd0, exp});
      chk("R11 header/tail low", {23'd0, got[25:17], got[0]}, 32'd0);
   endtask

   task automatic do_cmd(input int k, input logic [5:0] a, input logic [15:0] d);
      logic [31:0] got;
      frame_start();
      case (k)
         K_WR:    xfer({hdr(2'b01, a), 16'd0} | {16'd0, d}, 25, got);
         K_ER:    xfer(hdr(2'b11, a), 9, got);
         K_ERAL:  xfer(hdr(2'b00, 6'h20), 9, got);
         K_WRAL:  xfer({hdr(2'b00, 6'h10), 16'd0} | {16'd0, d}, 25, got);
         K_EN:    xfer(hdr(2'b00, 6'h30), 9, got);
         default: xfer(hdr(2'b00, 6'h00), 9, got);
      endcase
      frame_end();
   endtask

   initial begin
      logic [31:0] got;
      wait_n(5);
      chk("R1 sdo low in reset", {31'd0, sdo}, 32'd0);
      rst = 1'b0;
      wait_n(5);
      chk("R1 sdo low after reset", {31'd0, sdo}, 32'd0);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v][41:38] == 4'(K_RD))
            do_read(VEC[v][37:32], VEC[v][15:0], $sformatf("vector %0d", v));
         else
            do_cmd(int'(VEC[v][41:38]), VEC[v][37:32], VEC[v][31:16]);
      end

      // R10: write aborted after 10 data bits (latch still clear -> enable first)
      do_cmd(K_EN, 6'h00, 16'h0);
      frame_start();
      xfer({hdr(2'b01, 6'h07), 10'h2AB}, 19, got);
      frame_end();
      do_read(6'h07, 16'hFFFF, "R10 aborted write");

      // R2: leading zeros before start bit are skipped
      frame_start();
      xfer({3'b000, hdr(2'b01, 6'h15), 16'd0} | 32'h1357, 28, got);
      frame_end();
      do_read(6'h15, 16'h1357, "R2 leading zeros");

      // R11: select dropped in the middle of read data
      frame_start();
      xfer({hdr(2'b10, 6'h15), 4'd0}, 13, got);
      chk("R3 first read bits", got & 32'hF, 32'h1);
      sel = 1'b0; wait_n(8);
      chk("R11 sdo low after deselect", {31'd0, sdo}, 32'd0);
      sck = 1'b0; wait_n(8);

      // R1: reset mid-run clears array and latch
      rst = 1'b1; wait_n(4); rst = 1'b0; wait_n(4);
      do_read(6'h15, 16'h0000, "R1 array cleared");
      do_cmd(K_WR, 6'h15, 16'hAAAA);
      do_read(6'h15, 16'h0000, "R1 R9 latch cleared by reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule